// File: doc/BRIEF.md
# Shifted-Operand ALU with Condition Flags

This block is the data-processing stage of a 32-bit integer core. Each cycle it takes a first operand straight from a register. It takes a second operand that is either an immediate literal or a register value. The second operand passes through a barrel shifter in the same cycle, and the ALU then combines the two. The result appears combinationally together with a write-enable. Four condition flags live in a small register: negative, zero, carry and overflow.

The flags change only on a clock edge, and only when the caller asks for an update or the operation is a compare. What each flag means depends on the operation class. Arithmetic operations report the sign, carry and signed overflow of the adder. Logical operations take carry from the bit the shifter last pushed out, and leave negative and overflow as they were. Opcodes outside the supported set do nothing.

The block has no state machine. Its only sequential element is the flag register, with two states: hold and load. The register loads when a known opcode arrives with `set_flags` high, or when the opcode is a compare. It holds in every other cycle. An asynchronous reset clears it.

Top module: `shiftalu_core`

## Requirements
- R1: `op_code` selects the operation: 0 AND, 1 EOR (exclusive or), 2 SUB (opa minus operand), 4 ADD, 10 CMP, 12 ORR, 13 MOV, 15 MVN. `result_we` is 1 for every one of these except CMP.
- R2: When `use_imm` is 1, the second operand is `imm_b`. When it is 0, the second operand is `reg_b`.
- R3: `shift_kind` selects the shifter mode: 0 shift left, 1 logical shift right, 2 rotate right, 3 pass-through. `shift_amt` can be 0 to 31. The shifter carry-out is defined per mode:
  - shift left: the last bit moved past bit 31;
  - shift right: bit `shift_amt`-1 of the input;
  - rotate right: bit 31 of the rotated output.
- R4: When `shift_amt` is 0 or the mode is pass-through, the operand passes through unchanged and the shifter carry-out equals the current C flag.
- R5: MVN writes the bitwise NOT of the shifted second operand. MOV writes the shifted second operand.
- R6: When `set_flags` is 0 and the opcode is not CMP, all four flags keep their values across the clock edge.
- R7: On a flag update, Z becomes 1 exactly when the 32-bit result is zero. For ADD, SUB and CMP, N becomes bit 31 of the result.
- R8: ADD sets C to the carry out of bit 31. SUB and CMP set C to 1 when no borrow occurs (the carry out of opa + ~operand + 1).
- R9: ADD, SUB and CMP set V to 1 exactly on signed overflow.
- R10: A flag update from a logical operation (AND, EOR, ORR, MOV, MVN) sets C to the shifter carry-out and leaves N and V unchanged.
- R11: CMP updates all four flags whatever `set_flags` is, and never raises `result_we`.
- R12: Unused opcodes (3, 5 to 9, 11, 14) give `result_we` = 0 and leave the flags unchanged.
- R13: Reset (`rst_n` low, asynchronous) clears all four flags to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_code | input | 4 | Operation select |
| set_flags | input | 1 | Request a flag update this cycle |
| opa | input | 32 | First operand |
| reg_b | input | 32 | Register source for the second operand |
| imm_b | input | 32 | Immediate source for the second operand |
| use_imm | input | 1 | 1 selects `imm_b`, 0 selects `reg_b` |
| shift_kind | input | 2 | Shifter mode |
| shift_amt | input | 5 | Shift or rotate distance |
| result | output | 32 | Operation result |
| result_we | output | 1 | Result write-enable |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |

## Verification
The hardest behaviour to observe is that logical operations leave N and V untouched. At the ports this is only visible when both flags already hold 1. Otherwise a design that clears them would look correct. The stimulus therefore first runs an ADD that overflows from 0x7FFFFFFF into the sign bit, which sets both N and V. Logical operations with flag updates follow, and each one is checked for the preserved bits and for C taken from the shifter. The zero-distance carry pass-through is exercised the same way: C is first set to a known value, then a zero-distance operation is checked against it.

// File: rtl/shiftalu_pkg.sv
package shiftalu_pkg;

    typedef enum logic [3:0] {
        OP_AND = 4'd0,
        OP_EOR = 4'd1,
        OP_SUB = 4'd2,
        OP_ADD = 4'd4,
        OP_CMP = 4'd10,
        OP_ORR = 4'd12,
        OP_MOV = 4'd13,
        OP_MVN = 4'd15
    } alu_op_e;

    typedef enum logic [1:0] {
        SH_LSL  = 2'd0,
        SH_LSR  = 2'd1,
        SH_ROR  = 2'd2,
        SH_NONE = 2'd3
    } shift_kind_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

endpackage

// File: rtl/sal_shifter.sv
module sal_shifter
    import shiftalu_pkg::*;
#(
    parameter int W = 32,
    localparam int AW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  shift_kind_e   kind,
    input  logic [AW-1:0] amt,
    input  logic          cin,
    output logic [W-1:0]  dout,
    output logic          cout
);

    logic [W:0]   lsl_t;
    logic [W:0]   lsr_t;
    logic [W-1:0] ror_t;

    always_comb begin
        lsl_t = {1'b0, din} << amt;
        lsr_t = {din, 1'b0} >> amt;
        ror_t = (din >> amt) | (din << (W - int'(amt)));
        dout  = din;
        cout  = cin;
        if (amt != '0) begin
            unique case (kind)
                SH_LSL: begin
                    dout = lsl_t[W-1:0];
                    cout = lsl_t[W];
                end
                SH_LSR: begin
                    dout = lsr_t[W:1];
                    cout = lsr_t[0];
                end
                SH_ROR: begin
                    dout = ror_t;
                    cout = ror_t[W-1];
                end
                SH_NONE: begin
                    dout = din;
                    cout = cin;
                end
            endcase
        end
    end

endmodule

// File: rtl/sal_alu.sv
module sal_alu
    import shiftalu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [3:0]   op,
    input  logic         sh_c,
    input  nzcv_t        cur,
    output logic [W-1:0] res,
    output logic         wr,
    output logic         known,
    output logic         is_cmp,
    output nzcv_t        nxt
);

    logic [W-1:0] b_in;
    logic         c_in;
    logic         arith;
    logic [W:0]   sum;
    logic         ovf;

    // Operand conditioning for the shared adder
    always_comb begin
        b_in   = b;
        c_in   = 1'b0;
        arith  = 1'b0;
        known  = 1'b1;
        is_cmp = 1'b0;
        unique case (op)
            OP_ADD: arith = 1'b1;
            OP_SUB: begin
                arith = 1'b1;
                b_in  = ~b;
                c_in  = 1'b1;
            end
            OP_CMP: begin
                arith  = 1'b1;
                is_cmp = 1'b1;
                b_in   = ~b;
                c_in   = 1'b1;
            end
            OP_AND, OP_EOR, OP_ORR, OP_MOV, OP_MVN: arith = 1'b0;
            default: known = 1'b0;
        endcase
    end

    assign sum = {1'b0, a} + {1'b0, b_in} + {{W{1'b0}}, c_in};
    assign ovf = (a[W-1] == b_in[W-1]) && (sum[W-1] != a[W-1]);

    // Result selection
    always_comb begin
        res = '0;
        wr  = 1'b1;
        unique case (op)
            OP_AND:         res = a & b;
            OP_EOR:         res = a ^ b;
            OP_ORR:         res = a | b;
            OP_MOV:         res = b;
            OP_MVN:         res = ~b;
            OP_ADD, OP_SUB: res = sum[W-1:0];
            OP_CMP: begin
                res = sum[W-1:0];
                wr  = 1'b0;
            end
            default:        wr  = 1'b0;
        endcase
    end

    // Class-dependent next flag values
    always_comb begin
        nxt.n = arith ? res[W-1] : cur.n;
        nxt.z = (res == '0);
        nxt.c = arith ? sum[W] : sh_c;
        nxt.v = arith ? ovf : cur.v;
    end

endmodule

// File: rtl/sal_flagreg.sv
module sal_flagreg
    import shiftalu_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load,
    input  nzcv_t d,
    output nzcv_t q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end

endmodule

// File: rtl/shiftalu_core.sv
module shiftalu_core
    import shiftalu_pkg::*;
#(
    parameter int WIDTH = 32,
    localparam int AMT_W = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       op_code,
    input  logic             set_flags,
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] reg_b,
    input  logic [WIDTH-1:0] imm_b,
    input  logic             use_imm,
    input  logic [1:0]       shift_kind,
    input  logic [AMT_W-1:0] shift_amt,
    output logic [WIDTH-1:0] result,
    output logic             result_we,
    output logic             flag_n,
    output logic             flag_z,
    output logic             flag_c,
    output logic             flag_v
);

    logic [WIDTH-1:0] op2_raw;
    logic [WIDTH-1:0] op2_sh;
    logic             sh_carry;
    logic             op_known;
    logic             op_is_cmp;
    nzcv_t            flags_q;
    nzcv_t            flags_d;
    logic             flag_load;

    assign op2_raw = use_imm ? imm_b : reg_b;

    sal_shifter #(.W(WIDTH)) u_shifter (
        .din  (op2_raw),
        .kind (shift_kind_e'(shift_kind)),
        .amt  (shift_amt),
        .cin  (flags_q.c),
        .dout (op2_sh),
        .cout (sh_carry)
    );

    sal_alu #(.W(WIDTH)) u_alu (
        .a      (opa),
        .b      (op2_sh),
        .op     (op_code),
        .sh_c   (sh_carry),
        .cur    (flags_q),
        .res    (result),
        .wr     (result_we),
        .known  (op_known),
        .is_cmp (op_is_cmp),
        .nxt    (flags_d)
    );

    assign flag_load = op_known && (set_flags || op_is_cmp);

    sal_flagreg u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (flag_load),
        .d     (flags_d),
        .q     (flags_q)
    );

    assign flag_n = flags_q.n;
    assign flag_z = flags_q.z;
    assign flag_c = flags_q.c;
    assign flag_v = flags_q.v;

endmodule

// File: rtl/shiftalu_checker.sv
module shiftalu_checker #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic [3:0]   op_code,
    input logic         set_flags,
    input logic [W-1:0] result,
    input logic         result_we,
    input logic         flag_n,
    input logic         flag_z,
    input logic         flag_c,
    input logic         flag_v
);

    logic known;
    logic logical;
    logic is_cmp;

    assign is_cmp  = (op_code == 4'd10);
    assign logical = (op_code == 4'd0) || (op_code == 4'd1) || (op_code == 4'd12)
                  || (op_code == 4'd13) || (op_code == 4'd15);
    assign known   = logical || is_cmp || (op_code == 4'd2) || (op_code == 4'd4);

    assert_cmp_no_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        is_cmp |-> !result_we);

    assert_flags_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_flags && !is_cmp) |=> $stable({flag_n, flag_z, flag_c, flag_v}));

    assert_unused_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !known |=> $stable({flag_n, flag_z, flag_c, flag_v}));

    assert_unused_no_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !known |-> !result_we);

    assert_logic_keeps_nv_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (set_flags && logical) |=> ($stable(flag_n) && $stable(flag_v)));

    assert_zero_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (known && (set_flags || is_cmp)) |=> (flag_z == ($past(result) == '0)));

    assert_reset_clear_R13: assert property (@(posedge clk)
        !rst_n |=> ({flag_n, flag_z, flag_c, flag_v} == 4'b0000));

endmodule

bind shiftalu_core shiftalu_checker #(.W(WIDTH)) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_code   (op_code),
    .set_flags (set_flags),
    .result    (result),
    .result_we (result_we),
    .flag_n    (flag_n),
    .flag_z    (flag_z),
    .flag_c    (flag_c),
    .flag_v    (flag_v)
);

// File: tb/shiftalu_core_bench.sv
module shiftalu_core_bench;

    logic        clk;
    logic        rst_n;
    logic [3:0]  op_code;
    logic        set_flags;
    logic [31:0] opa;
    logic [31:0] reg_b;
    logic [31:0] imm_b;
    logic        use_imm;
    logic [1:0]  shift_kind;
    logic [4:0]  shift_amt;
    logic [31:0] result;
    logic        result_we;
    logic        flag_n;
    logic        flag_z;
    logic        flag_c;
    logic        flag_v;

    int tests;
    int fails;

    shiftalu_core u_shiftalu_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_code    (op_code),
        .set_flags  (set_flags),
        .opa        (opa),
        .reg_b      (reg_b),
        .imm_b      (imm_b),
        .use_imm    (use_imm),
        .shift_kind (shift_kind),
        .shift_amt  (shift_amt),
        .result     (result),
        .result_we  (result_we),
        .flag_n     (flag_n),
        .flag_z     (flag_z),
        .flag_c     (flag_c),
        .flag_v     (flag_v)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one operation at the falling edge, check result, then flags after the rise
    task automatic exec(input string tag, input logic [3:0] op, input logic sf,
                        input logic [31:0] a, input logic [31:0] rb,
                        input logic ui, input logic [31:0] imm,
                        input logic [1:0] k, input logic [4:0] amt,
                        input bit chk_res, input logic [31:0] exp_res,
                        input logic exp_we, input logic [3:0] exp_nzcv);
        @(negedge clk);
        op_code = op; set_flags = sf; opa = a; reg_b = rb;
        use_imm = ui; imm_b = imm; shift_kind = k; shift_amt = amt;
        #1;
        if (chk_res) check({tag, " result"}, result, exp_res);
        check({tag, " write-enable"}, {31'd0, result_we}, {31'd0, exp_we});
        @(posedge clk);
        #1;
        check({tag, " flags nzcv"}, {28'd0, flag_n, flag_z, flag_c, flag_v}, {28'd0, exp_nzcv});
    endtask

    task automatic t_reset;
        check("R13 flags in reset", {28'd0, flag_n, flag_z, flag_c, flag_v}, 32'd0);
    endtask

    task automatic t_arith;
        exec("R9 add overflow",     4'd4, 1'b1, 32'h7FFFFFFF, 32'd1, 1'b0, 32'd0, 2'd0, 5'd0, 1, 32'h80000000, 1'b1, 4'b1001);
        exec("R8 add carry zero",   4'd4, 1'b1, 32'hFFFFFFFF, 32'd1, 1'b0, 32'd0, 2'd0, 5'd0, 1, 32'h0,        1'b1, 4'b0110);
        exec("R8 sub no borrow",    4'd2, 1'b1, 32'd5,        32'd3, 1'b0, 32'd0, 2'd0, 5'd0, 1, 32'd2,        1'b1, 4'b0010);
        exec("R7 sub negative",     4'd2, 1'b1, 32'd3,        32'd5, 1'b0, 32'd0, 2'd0, 5'd0, 1, 32'hFFFFFFFE, 1'b1, 4'b1000);
        exec("R9 sub overflow",     4'd2, 1'b1, 32'h80000000, 32'd1, 1'b0, 32'd0, 2'd0, 5'd0, 1, 32'h7FFFFFFF, 1'b1, 4'b0011);
    endtask

    task automatic t_hold;
        exec("R6 add without set",  4'd4, 1'b0, 32'd0, 32'd0, 1'b0, 32'd0, 2'd0, 5'd0, 1, 32'd0, 1'b1, 4'b0011);
    endtask

    task automatic t_cmp;
        exec("R11 cmp equal",       4'd10, 1'b0, 32'd7, 32'd7, 1'b0, 32'd0, 2'd0, 5'd0, 0, 32'd0, 1'b0, 4'b0110);
        exec("R11 cmp less",        4'd10, 1'b0, 32'd3, 32'd5, 1'b0, 32'd0, 2'd0, 5'd0, 0, 32'd0, 1'b0, 4'b1000);
    endtask

    task automatic t_logical;
        exec("R10 prime N and V",   4'd4, 1'b1, 32'h7FFFFFFF, 32'd1, 1'b0, 32'd0, 2'd0, 5'd0, 1, 32'h80000000, 1'b1, 4'b1001);
        exec("R10 and with lsr",    4'd0, 1'b1, 32'hF0F0F0F0, 32'h0F0F0F0F, 1'b0, 32'd0, 2'd1, 5'd4, 1, 32'h00F0F0F0, 1'b1, 4'b1011);
        exec("R4 eor zero amount",  4'd1, 1'b1, 32'h12345678, 32'd0, 1'b1, 32'h12345678, 2'd0, 5'd0, 1, 32'h0, 1'b1, 4'b1111);
        exec("R10 orr with lsl",    4'd12, 1'b1, 32'd0, 32'd1, 1'b0, 32'd0, 2'd0, 5'd1, 1, 32'd2, 1'b1, 4'b1001);
    endtask

    task automatic t_shift;
        exec("R3 prime",            4'd4, 1'b1, 32'h7FFFFFFF, 32'd1, 1'b0, 32'd0, 2'd0, 5'd0, 1, 32'h80000000, 1'b1, 4'b1001);
        exec("R3 mov ror 1",        4'd13, 1'b1, 32'd0, 32'h80000001, 1'b0, 32'd0, 2'd2, 5'd1,  1, 32'hC0000000, 1'b1, 4'b1011);
        exec("R3 mov lsr 31",       4'd13, 1'b1, 32'd0, 32'h80000000, 1'b0, 32'd0, 2'd1, 5'd31, 1, 32'h00000001, 1'b1, 4'b1001);
        exec("R3 mov lsr 1",        4'd13, 1'b1, 32'd0, 32'h00000003, 1'b0, 32'd0, 2'd1, 5'd1,  1, 32'h00000001, 1'b1, 4'b1011);
        exec("R3 mov lsl 31",       4'd13, 1'b1, 32'd0, 32'h00000001, 1'b0, 32'd0, 2'd0, 5'd31, 1, 32'h80000000, 1'b1, 4'b1001);
        exec("R3 mov lsl 31 carry", 4'd13, 1'b1, 32'd0, 32'h00000003, 1'b0, 32'd0, 2'd0, 5'd31, 1, 32'h80000000, 1'b1, 4'b1011);
        exec("R4 pass-through",     4'd13, 1'b1, 32'd0, 32'h0000ABCD, 1'b0, 32'd0, 2'd3, 5'd5,  1, 32'h0000ABCD, 1'b1, 4'b1011);
        exec("R2 immediate select", 4'd13, 1'b0, 32'd0, 32'h000000AA, 1'b1, 32'h55, 2'd0, 5'd0, 1, 32'h00000055, 1'b1, 4'b1011);
        exec("R2 register select",  4'd13, 1'b0, 32'd0, 32'h000000AA, 1'b0, 32'h55, 2'd0, 5'd0, 1, 32'h000000AA, 1'b1, 4'b1011);
        exec("R5 mvn",              4'd15, 1'b0, 32'd0, 32'h0000FFFF, 1'b0, 32'd0, 2'd0, 5'd8,  1, 32'hFF0000FF, 1'b1, 4'b1011);
        exec("R1 and basic",        4'd0, 1'b0, 32'hFF00FF00, 32'h0FF00FF0, 1'b0, 32'd0, 2'd0, 5'd0, 1, 32'h0F000F00, 1'b1, 4'b1011);
    endtask

    task automatic t_unused;
        logic [3:0] bad [8] = '{4'd3, 4'd5, 4'd6, 4'd7, 4'd8, 4'd9, 4'd11, 4'd14};
        for (int i = 0; i < 8; i++) begin
            exec("R12 unused opcode", bad[i], 1'b1, 32'd0, 32'd0, 1'b0, 32'd0, 2'd0, 5'd0, 0, 32'd0, 1'b0, 4'b1011);
        end
    endtask

    task automatic t_async_reset;
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R13 async clear", {28'd0, flag_n, flag_z, flag_c, flag_v}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R13 watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        tests = 0; fails = 0;
        rst_n = 1'b0; op_code = 4'd0; set_flags = 1'b0; opa = '0; reg_b = '0;
        imm_b = '0; use_imm = 1'b0; shift_kind = 2'd0; shift_amt = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_arith();
        t_hold();
        t_cmp();
        t_logical();
        t_shift();
        t_unused();
        t_async_reset();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule